// File: doc/BRIEF.md
# Lane-Partitioned Packed Adder

This block adds two packed operand words as four independent unsigned lanes. The carry chain is broken at every lane boundary, so a carry out of one lane never reaches the next. Each lane reports its own carry flag. When saturation is enabled, a lane that overflows is clamped to its maximum value instead of wrapping.

The lane width can be set from 10 to 14 bits. Each lane occupies a slot of 12 bits, or of the lane width if that is larger. The packed ports are therefore sized for four 14-bit slots.

Operands, mode and saturation enable are captured together on a valid strobe. The sum, the carry flags and a valid flag are presented one clock later. Outputs hold between operations.

Top module: `lane_split_adder`

## Requirements
- R1: The lane width W comes from the `mode` code as W = 10 + mode for codes 0 to 4; codes 5 to 7 select W = 14.
- R2: The slot size S is 12 when W ≤ 12 and W otherwise. Lane i (i = 0..3) occupies bits [i*S +: S] of `a`, `b` and `sum`, with lane 0 in the least significant slot.
- R3: Each lane result equals (a_i + b_i) mod 2^W, where a_i and b_i are the low W bits of the lane's slot. Operand bits in the slot above W, and operand bits above 4*S, have no effect.
- R4: `carry[i]` is 1 exactly when a_i + b_i ≥ 2^W. No carry passes between lanes.
- R5: When `sat_en` was 1 for the operation, a lane whose `carry` is set presents 2^W − 1. The carry flag is still reported.
- R6: In `sum`, the slot bits above W and all bits above 4*S are zero.
- R7: `out_valid` is 1 in exactly the cycle after a clock edge at which `in_valid` was 1 and `rst` was 0.
- R8: `mode` and `sat_en` are captured with the operands. While `in_valid` is 0, `sum` and `carry` hold their last values.
- R9: A synchronous reset clears `out_valid`, `sum` and `carry` to zero, and discards any operation presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Capture operands, mode and saturation enable |
| mode | input | 3 | Lane width code |
| sat_en | input | 1 | Clamp overflowing lanes to all ones |
| a | input | 56 | Packed first operand |
| b | input | 56 | Packed second operand |
| out_valid | output | 1 | Result presented this cycle |
| sum | output | 56 | Packed lane results |
| carry | output | 4 | Per-lane carry out, bit i for lane i |

## Verification
Every result is due one clock edge after the edge that captured its operation. `sum` and `carry` then hold until the next capture or reset. The bench updates its reference model at the same edge where it drives the operation, and compares `out_valid`, `sum` and `carry` a quarter period after every edge. An output that arrives a cycle early or late, or that drifts while idle, therefore shows up as a mismatch on that very cycle. The test set covers all-ones operands in every mode, with and without saturation, junk bits outside the lanes, random operands in every mode, mode changes between back-to-back operations, and a reset that coincides with a valid strobe.

// File: rtl/lane_split_adder.sv
module lane_split_adder #(
  parameter int LANES     = 4,
  parameter int MIN_W     = 10,
  parameter int MAX_W     = 14,
  parameter int BASE_SLOT = 12,
  parameter int CODE_W    = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [CODE_W-1:0]      mode,
  input  logic                   sat_en,
  input  logic [LANES*MAX_W-1:0] a,
  input  logic [LANES*MAX_W-1:0] b,
  output logic                   out_valid,
  output logic [LANES*MAX_W-1:0] sum,
  output logic [LANES-1:0]       carry
);
  localparam int DW = LANES * MAX_W;
  localparam int SW = MAX_W + 1;

  logic [DW-1:0]     a_q, b_q;
  logic [CODE_W-1:0] mode_q;
  logic              sat_q, vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      a_q    <= '0;
      b_q    <= '0;
      mode_q <= '0;
      sat_q  <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        a_q    <= a;
        b_q    <= b;
        mode_q <= mode;
        sat_q  <= sat_en;
      end
    end
  end

  function automatic int width_of(logic [CODE_W-1:0] m);
    int w;
    w = MIN_W + int'(m);
    return (w > MAX_W) ? MAX_W : w;
  endfunction

  always_comb begin
    int w, s;
    logic [SW-1:0] lmask, la, lb, tot, lane;
    w     = width_of(mode_q);
    s     = (w < BASE_SLOT) ? BASE_SLOT : w;
    lmask = (SW'(1) << w) - SW'(1);
    sum   = '0;
    carry = '0;
    for (int i = 0; i < LANES; i++) begin
      la       = SW'(a_q >> (i * s)) & lmask;
      lb       = SW'(b_q >> (i * s)) & lmask;
      tot      = la + lb;
      carry[i] = |(tot >> w);
      lane     = (sat_q && carry[i]) ? lmask : (tot & lmask);
      sum      = sum | (DW'(lane) << (i * s));
    end
  end

  assign out_valid = vld_q;

  // R7: one-cycle latency of the valid flag
  p_valid_follows_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_no_spurious_valid_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R9: reset clears valid
  p_reset_clears_r9: assert property (@(posedge clk)
    rst |=> (!out_valid && carry == '0));

  // R5: saturated lane 1 in the narrowest mode is all ones
  p_sat_clamp_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && sat_q && mode_q == '0 && carry[1])
      |-> sum[BASE_SLOT +: MIN_W] == {MIN_W{1'b1}});

  // R6: spare slot bits and bits above the four slots are zero in 12-bit slot modes
  p_spare_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_q == '0) |-> (sum[BASE_SLOT-1:MIN_W] == '0 && sum[DW-1:LANES*BASE_SLOT] == '0));
endmodule

// File: tb/sim_lane_split_adder.sv
module sim_lane_split_adder;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  mode = '0;
  logic        sat_en = 1'b0;
  logic [55:0] a = '0, b = '0;
  logic        out_valid;
  logic [55:0] sum;
  logic [3:0]  carry;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  logic        exp_v = 1'b0;
  logic [55:0] exp_sum = '0;
  logic [3:0]  exp_c = '0;

  lane_split_adder u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .sat_en(sat_en),
    .a(a), .b(b), .out_valid(out_valid), .sum(sum), .carry(carry)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
      report();
    end
  end

  task automatic model(logic [2:0] m, bit sat, logic [55:0] x, logic [55:0] y);
    longint w, s, lim, xa, ya, t, r;
    w = (m > 3'd4) ? 14 : 10 + longint'(m);
    s = (w > 12) ? w : 12;
    lim = 64'd1 << w;
    exp_sum = '0;
    exp_c = '0;
    for (int i = 0; i < 4; i++) begin
      xa = longint'((x >> (i * s))) % lim;
      ya = longint'((y >> (i * s))) % lim;
      t = xa + ya;
      exp_c[i] = (t >= lim);
      if (t >= lim) r = sat ? lim - 1 : t - lim;
      else r = t;
      exp_sum = exp_sum | (56'(r) << (i * s));
    end
  endtask

  task automatic check(string tag);
    checks++;
    if (out_valid !== exp_v) begin
      fails++;
      $display("FAIL %s out_valid: actual %0b expected %0b", tag, out_valid, exp_v);
    end
    checks++;
    if (sum !== exp_sum) begin
      fails++;
      $display("FAIL %s sum: actual %h expected %h", tag, sum, exp_sum);
    end
    checks++;
    if (carry !== exp_c) begin
      fails++;
      $display("FAIL %s carry: actual %b expected %b", tag, carry, exp_c);
    end
  endtask

  task automatic step(bit r, bit v, logic [2:0] m, bit sat,
                      logic [55:0] x, logic [55:0] y, string tag);
    rst = r; in_valid = v; mode = m; sat_en = sat; a = x; b = y;
    @(posedge clk);
    if (r) begin
      exp_v = 1'b0; exp_sum = '0; exp_c = '0;
    end else begin
      exp_v = v;
      if (v) model(m, sat, x, y);
    end
    #(PERIOD/4);
    check(tag);
  endtask

  function automatic logic [55:0] rnd56();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    // R9: reset state
    step(1, 0, 3'd0, 0, '0, '0, "R9 reset");
    step(1, 1, 3'd2, 1, '1, '1, "R9 reset");

    // R3 R4 R5 R6 R1: all-ones in every mode, wrap then saturate
    for (int m = 0; m < 8; m++) begin
      step(0, 1, 3'(m), 0, '1, '1, "R3/R4/R6 all-ones wrap");
      step(0, 1, 3'(m), 1, '1, '1, "R5/R4/R6 all-ones sat");
    end

    // R3: single-lane carry must not reach neighbour (12-bit lanes)
    step(0, 1, 3'd2, 0, 56'h000_000_FFF_FFF, 56'h000_000_001_000, "R4/R2 isolation");
    step(0, 1, 3'd0, 0, 56'hFF_C00_C00_C00_C00, 56'h00_C00_400_000_001, "R3/R6 junk bits");

    // R8: idle holds outputs
    step(0, 0, 3'd4, 1, rnd56(), rnd56(), "R8 idle hold");
    step(0, 0, 3'd1, 0, rnd56(), rnd56(), "R8 idle hold");

    // R1 R2 R3 R4 R5: random in every mode, mode changes back to back
    for (int n = 0; n < 400; n++)
      step(0, 1, 3'($urandom_range(0, 7)), 1'($urandom()), rnd56(), rnd56(), "R1/R2/R3/R5 random");

    // R7: gaps between operations
    for (int n = 0; n < 60; n++)
      step(0, 1'($urandom()), 3'($urandom_range(0, 7)), 1'($urandom()), rnd56(), rnd56(), "R7/R8 gaps");

    // R9: reset while a valid strobe is present
    step(0, 1, 3'd3, 0, '1, '1, "R9 pre-reset");
    step(1, 1, 3'd3, 1, '1, '1, "R9 reset discards op");
    step(0, 0, 3'd3, 1, '1, '1, "R9 after reset");

    report();
  end
endmodule